// File: doc/BRIEF.md
# Zero-Suppressed Hit Readout Pipeline

This block takes the digitised output of a 128-channel strip front end and pushes it off chip with no trigger. Each channel reports a hit flag and a 3-bit amplitude code. Once per beam-crossing period, marked by a one-cycle strobe on `bco_i`, the block captures a snapshot of all channels into one of four rotating event paths. Channels without a hit are dropped. Up to four hit words per event are shifted out on two serial lines. Events move through three phases, one per beam-crossing period. While one path captures, the path before it is reduced to a hit list and the path before that is serialized. New events are therefore written in the same cycles that older events are read out.

The block runs on the serial clock `clk`. Each output word is 12 bits, laid out from MSB to LSB as the 7-bit channel number, the 3-bit amplitude and the 2-bit path tag. Each line carries one half of the word, 6 bits per word, so four words take 24 serial cycles. The beam-crossing strobe must therefore come at least 24 cycles apart. If an event has more than four hits, the four lowest-numbered channels are sent and an overflow flag marks that event while it is being serialized.

Top module: `zs_hit_readout`

## Requirements
- R1: A synchronous active-high reset drives `sdo_o`, `sdv_o` and `ovf_o` low. It clears every captured path and every pending hit list, so no event captured before the reset is ever transmitted.
- R2: On each clock edge where `bco_i` is high, `hit_i` and `amp_i` are captured into the current path. The path index counts 0, 1, 2, 3, 0, … starting at 0 after reset. The index appears as the 2-bit tag in the LSBs of each word of that event.
- R3: Only channels whose hit bit is set produce words. Words of one event are sent in ascending channel order, and a hit with amplitude 0 is still sent.
- R4: When an event has more than four hits, only the four lowest-numbered channels are sent and the rest are discarded.
- R5: `ovf_o` is high from the edge that starts serializing an event with more than four hits until the next strobe edge. It is low for every other event.
- R6: An event captured at strobe n starts leaving the block at the edge of strobe n+2. Word k (k = 0..3) occupies the 6 serial cycles 6k to 6k+5 after that edge.
- R7: Word layout is {channel[6:0], amplitude[2:0], tag[1:0]}. In serial cycle j of a word (j = 0..5), `sdo_o[1]` carries word bit 11-j and `sdo_o[0]` carries word bit 5-j, so both halves go out MSB first.
- R8: `sdv_o` is high exactly in the serial cycles that carry a word. In every other cycle `sdo_o` and `sdv_o` are low: after an event's last word, for events with no hits, and before any event arrives.
- R9: Capture goes on at every strobe while earlier events are serialized, so back-to-back events at the minimum 24-cycle spacing are all delivered intact.
- R10: When strobes come more than 24 cycles apart, the lines stay idle low after the 24th serial cycle until the next strobe, and `ovf_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock |
| rst | input | 1 | Synchronous active-high reset |
| bco_i | input | 1 | One-cycle beam-crossing strobe, at least 24 cycles apart |
| hit_i | input | 128 | Per-channel hit flag |
| amp_i | input | 384 | Per-channel 3-bit amplitude, channel c at bits 3c+2:3c |
| sdo_o | output | 2 | Serial data lines, upper word half on bit 1 |
| sdv_o | output | 1 | High while the lines carry word bits |
| ovf_o | output | 1 | Event now being serialized had more than four hits |

## Verification
The hardest case to reach from the ports is when suppression, capture and serialization all act on different paths in the same period while an overflowing event is being truncated. A reset must also land while two events are still queued inside the pipeline. The stimulus table sends events back to back at the minimum strobe spacing, with channels listed out of order and overflow events of five and six hits placed next to sparse ones. Directed runs then send all 128 channels hit at once and stretch the strobe spacing. They also assert reset with two events in flight and check that the next two output periods are idle and that the tag restarts at 0.

// File: rtl/zs_pkg.sv
package zs_pkg;
  localparam int CHANNELS = 128;
  localparam int AMP_BITS = 3;
  localparam int PATHS    = 4;
  localparam int MAX_HITS = 4;
  localparam int LANES    = 2;
endpackage

// File: rtl/zs_path_store.sv
module zs_path_store #(
  parameter int NCH   = zs_pkg::CHANNELS,
  parameter int AMPW  = zs_pkg::AMP_BITS,
  parameter int NPATH = zs_pkg::PATHS,
  localparam int TAGW = $clog2(NPATH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [TAGW-1:0]     wr_idx,
  input  logic [NCH-1:0]      wr_hit,
  input  logic [NCH*AMPW-1:0] wr_amp,
  input  logic [TAGW-1:0]     ra_idx,
  output logic [NCH-1:0]      ra_hit,
  input  logic [TAGW-1:0]     rb_idx,
  output logic [NCH*AMPW-1:0] rb_amp
);
  logic [NCH-1:0]      hit_mem [NPATH];
  logic [NCH*AMPW-1:0] amp_mem [NPATH];

  // hit masks need a reset so cleared paths report no hits
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NPATH; p++) hit_mem[p] <= '0;
    end else if (wr_en) begin
      hit_mem[wr_idx] <= wr_hit;
    end
  end

  // amplitudes are only read behind a hit bit, so no reset: RAM friendly
  always_ff @(posedge clk) begin
    if (wr_en) amp_mem[wr_idx] <= wr_amp;
  end

  assign ra_hit = hit_mem[ra_idx];
  assign rb_amp = amp_mem[rb_idx];
endmodule

// File: rtl/zs_suppress.sv
module zs_suppress #(
  parameter int NCH   = zs_pkg::CHANNELS,
  parameter int AMPW  = zs_pkg::AMP_BITS,
  parameter int NPATH = zs_pkg::PATHS,
  parameter int MAXH  = zs_pkg::MAX_HITS,
  localparam int CHW    = $clog2(NCH),
  localparam int TAGW   = $clog2(NPATH),
  localparam int WORD_W = CHW + AMPW + TAGW,
  localparam int CNTW   = $clog2(MAXH + 1),
  localparam int SLW    = (MAXH > 1) ? $clog2(MAXH) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [TAGW-1:0]        ld_tag,
  input  logic [NCH-1:0]         ld_hit,
  output logic [TAGW-1:0]        amp_idx,
  input  logic [NCH*AMPW-1:0]    amp_in,
  input  logic [TAGW-1:0]        rl_idx,
  output logic [MAXH*WORD_W-1:0] rl_words,
  output logic [CNTW-1:0]        rl_cnt,
  output logic                   rl_ovf
);
  logic [NCH-1:0]    mask_q;
  logic [TAGW-1:0]   tag_q;
  logic [CNTW-1:0]   cnt_q;
  logic [WORD_W-1:0] wl_q [NPATH][MAXH];
  logic [CNTW-1:0]   lc_q [NPATH];
  logic              ovf_q [NPATH];

  logic            pick_v;
  logic [CHW-1:0]  pick_idx;
  logic [AMPW-1:0] amp_sel;
  logic            room;

  // lowest pending channel wins
  always_comb begin
    pick_v   = 1'b0;
    pick_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask_q[i]) begin
        pick_v   = 1'b1;
        pick_idx = CHW'(i);
      end
    end
  end

  assign amp_sel = amp_in[pick_idx*AMPW +: AMPW];
  assign room    = (cnt_q < CNTW'(MAXH));
  assign amp_idx = tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      tag_q  <= '0;
      cnt_q  <= '0;
      for (int p = 0; p < NPATH; p++) begin
        lc_q[p]  <= '0;
        ovf_q[p] <= 1'b0;
      end
    end else if (start) begin
      mask_q       <= ld_hit;
      tag_q        <= ld_tag;
      cnt_q        <= '0;
      lc_q[ld_tag]  <= '0;
      ovf_q[ld_tag] <= 1'b0;
    end else if (pick_v) begin
      if (room) begin
        mask_q[pick_idx] <= 1'b0;
        cnt_q            <= cnt_q + 1'b1;
        lc_q[tag_q]      <= cnt_q + 1'b1;
      end else begin
        ovf_q[tag_q] <= 1'b1;
        mask_q       <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && !start && pick_v && room)
      wl_q[tag_q][cnt_q[SLW-1:0]] <= {pick_idx, amp_sel, tag_q};
  end

  always_comb begin
    for (int k = 0; k < MAXH; k++) rl_words[k*WORD_W +: WORD_W] = wl_q[rl_idx][k];
  end
  assign rl_cnt = lc_q[rl_idx];
  assign rl_ovf = ovf_q[rl_idx];

  a_r4_cnt_cap: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNTW'(MAXH));

  a_r3_ascending: assert property (@(posedge clk) disable iff (rst)
    (!start && pick_v && room) |=> (start || !pick_v || pick_idx > $past(pick_idx)));
endmodule

// File: rtl/zs_serializer.sv
module zs_serializer #(
  parameter int MAXH   = zs_pkg::MAX_HITS,
  parameter int WORD_W = 12,
  parameter int LANES  = zs_pkg::LANES,
  localparam int CNTW = $clog2(MAXH + 1),
  localparam int HALF = WORD_W / LANES,
  localparam int BW   = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [MAXH*WORD_W-1:0] ld_words,
  input  logic [CNTW-1:0]        ld_cnt,
  input  logic                   ld_ovf,
  output logic [LANES-1:0]       sdo_o,
  output logic                   sdv_o,
  output logic                   ovf_o
);
  logic [MAXH*WORD_W-1:0] words_q, words_n;
  logic [CNTW-1:0]        cnt_q, cnt_n, slot_q, slot_n;
  logic [BW-1:0]          bit_q, bit_n;
  logic                   ovf_n, vld_n;
  logic [WORD_W-1:0]      wsel;
  logic [LANES-1:0]       sdo_n;

  always_comb begin
    words_n = words_q;
    cnt_n   = cnt_q;
    ovf_n   = ovf_o;
    slot_n  = slot_q;
    bit_n   = bit_q;
    if (load) begin
      words_n = ld_words;
      cnt_n   = ld_cnt;
      ovf_n   = ld_ovf;
      slot_n  = '0;
      bit_n   = '0;
    end else if (slot_q < CNTW'(MAXH)) begin
      if (bit_q == BW'(HALF - 1)) begin
        bit_n  = '0;
        slot_n = slot_q + 1'b1;
      end else begin
        bit_n = bit_q + 1'b1;
      end
    end
    wsel = '0;
    for (int k = 0; k < MAXH; k++)
      if (slot_n == CNTW'(k)) wsel = words_n[k*WORD_W +: WORD_W];
    vld_n = (slot_n < CNTW'(MAXH)) && (slot_n < cnt_n);
    for (int l = 0; l < LANES; l++)
      sdo_n[l] = vld_n & wsel[(l + 1)*HALF - 1 - int'(bit_n)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      words_q <= '0;
      cnt_q   <= '0;
      slot_q  <= CNTW'(MAXH);
      bit_q   <= '0;
      sdo_o   <= '0;
      sdv_o   <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      words_q <= words_n;
      cnt_q   <= cnt_n;
      slot_q  <= slot_n;
      bit_q   <= bit_n;
      sdo_o   <= sdo_n;
      sdv_o   <= vld_n;
      ovf_o   <= ovf_n;
    end
  end

  a_r6_first_slot: assert property (@(posedge clk) disable iff (rst)
    load |=> (slot_q == '0 && bit_q == '0));

  a_r8_idle_tail: assert property (@(posedge clk) disable iff (rst)
    (slot_q == CNTW'(MAXH)) |-> (!sdv_o && sdo_o == '0));
endmodule

// File: rtl/zs_hit_readout.sv
module zs_hit_readout #(
  parameter int NCH   = zs_pkg::CHANNELS,
  parameter int AMPW  = zs_pkg::AMP_BITS,
  parameter int NPATH = zs_pkg::PATHS,
  parameter int MAXH  = zs_pkg::MAX_HITS,
  parameter int LANES = zs_pkg::LANES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bco_i,
  input  logic [NCH-1:0]      hit_i,
  input  logic [NCH*AMPW-1:0] amp_i,
  output logic [LANES-1:0]    sdo_o,
  output logic                sdv_o,
  output logic                ovf_o
);
  localparam int CHW    = $clog2(NCH);
  localparam int TAGW   = $clog2(NPATH);
  localparam int WORD_W = CHW + AMPW + TAGW;
  localparam int CNTW   = $clog2(MAXH + 1);

  logic [TAGW-1:0]        wp_q, sup_idx, ser_idx, amp_idx;
  logic [NCH-1:0]         sup_hit;
  logic [NCH*AMPW-1:0]    sup_amp;
  logic [MAXH*WORD_W-1:0] rl_words;
  logic [CNTW-1:0]        rl_cnt;
  logic                   rl_ovf;

  always_ff @(posedge clk) begin
    if (rst)        wp_q <= '0;
    else if (bco_i) wp_q <= wp_q + 1'b1;
  end

  assign sup_idx = wp_q - TAGW'(1);
  assign ser_idx = wp_q - TAGW'(2);

  zs_path_store #(.NCH(NCH), .AMPW(AMPW), .NPATH(NPATH)) store_i (
    .clk(clk), .rst(rst), .wr_en(bco_i), .wr_idx(wp_q),
    .wr_hit(hit_i), .wr_amp(amp_i),
    .ra_idx(sup_idx), .ra_hit(sup_hit),
    .rb_idx(amp_idx), .rb_amp(sup_amp)
  );

  zs_suppress #(.NCH(NCH), .AMPW(AMPW), .NPATH(NPATH), .MAXH(MAXH)) supp_i (
    .clk(clk), .rst(rst), .start(bco_i), .ld_tag(sup_idx), .ld_hit(sup_hit),
    .amp_idx(amp_idx), .amp_in(sup_amp),
    .rl_idx(ser_idx), .rl_words(rl_words), .rl_cnt(rl_cnt), .rl_ovf(rl_ovf)
  );

  zs_serializer #(.MAXH(MAXH), .WORD_W(WORD_W), .LANES(LANES)) ser_i (
    .clk(clk), .rst(rst), .load(bco_i),
    .ld_words(rl_words), .ld_cnt(rl_cnt), .ld_ovf(rl_ovf),
    .sdo_o(sdo_o), .sdv_o(sdv_o), .ovf_o(ovf_o)
  );

  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sdo_o == '0 && !sdv_o && !ovf_o));

  a_r2_wp_step: assert property (@(posedge clk) disable iff (rst)
    bco_i |=> (wp_q == $past(wp_q) + TAGW'(1)));
endmodule

// File: tb/zs_hit_readout_tb_top.sv
module zs_hit_readout_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH    = 128;
  localparam int MAXH   = 4;
  localparam int HALF   = 6;
  localparam int PERIOD = 24;
  localparam int NV     = 8;

  // six channel slots per vector, -1 marks an unused slot
  localparam int TCH [NV*6] = '{
    -1, -1, -1, -1, -1, -1,
     5, -1, -1, -1, -1, -1,
   127,  0, -1, -1, -1, -1,
    10, 11, 12, 13, -1, -1,
   100,  3, 64,  2, 90,  1,
   127,126,125,124,  0, -1,
    63, 64, -1, -1, -1, -1,
    42, -1, -1, -1, -1, -1};
  localparam int TAMP [NV*6] = '{
    0, 0, 0, 0, 0, 0,
    3, 0, 0, 0, 0, 0,
    7, 1, 0, 0, 0, 0,
    2, 4, 6, 0, 0, 0,
    1, 2, 3, 4, 5, 6,
    7, 6, 5, 4, 3, 0,
    5, 2, 0, 0, 0, 0,
    0, 0, 0, 0, 0, 0};

  logic           clk = 1'b0, rst = 1'b1, bco = 1'b0;
  logic [127:0]   hit = '0;
  logic [383:0]   amp = '0;
  logic [1:0]     sdo;
  logic           sdv, ovf;
  int checks = 0, errors = 0;

  logic [127:0] hh [2];
  logic [383:0] ha [2];
  int           ht [2];
  string        hr [2];
  int           ev_num = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zs_hit_readout dut_i (
    .clk(clk), .rst(rst), .bco_i(bco), .hit_i(hit), .amp_i(amp),
    .sdo_o(sdo), .sdv_o(sdv), .ovf_o(ovf)
  );

  function automatic string vreq(int v);
    case (v)
      0: return "R8"; 1: return "R7"; 2: return "R3"; 3: return "R6";
      4: return "R4"; 5: return "R5"; 6: return "R9"; default: return "R3";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_hist(string req);
    for (int i = 0; i < 2; i++) begin
      hh[i] = '0; ha[i] = '0; ht[i] = 0; hr[i] = req;
    end
    ev_num = 0;
  endtask

  // called at a falling edge; runs one strobe period and checks the event from two strobes ago
  task automatic period(input logic [127:0] h, input logic [383:0] a, input string req, input int extra);
    logic [11:0] ew [4];
    int ec, at, act_v, exp_v;
    bit eo, bad;
    logic [1:0] es;
    logic ev;
    ec = 0; eo = 1'b0; bad = 1'b0; at = 0; act_v = 0; exp_v = 0;
    for (int c = 0; c < NCH; c++) begin
      if (hh[0][c]) begin
        if (ec < MAXH) begin
          ew[ec] = {7'(c), ha[0][c*3 +: 3], 2'(ht[0])};
          ec++;
        end else eo = 1'b1;
      end
    end
    bco = 1'b1; hit = h; amp = a;
    @(posedge clk);
    for (int k = 0; k < PERIOD + extra; k++) begin
      @(negedge clk);
      if (k == 0) bco = 1'b0;
      es = 2'b00; ev = 1'b0;
      if (k < PERIOD && (k / HALF) < ec) begin
        ev = 1'b1;
        es = {ew[k/HALF][11 - k%HALF], ew[k/HALF][5 - k%HALF]};
      end
      if (!bad && (sdo != es || sdv != ev || ovf != eo)) begin
        bad = 1'b1; at = k;
        act_v = {ovf, sdv, sdo}; exp_v = {eo, ev, es};
      end
    end
    check(!bad, hr[0], $sformatf("cycle %0d {ovf,sdv,sdo}", at), act_v, exp_v);
    hh[0] = hh[1]; ha[0] = ha[1]; ht[0] = ht[1]; hr[0] = hr[1];
    hh[1] = h; ha[1] = a; ht[1] = ev_num % 4; hr[1] = req;
    ev_num++;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] h;
    logic [383:0] a;
    clear_hist("R8");
    repeat (3) @(negedge clk);
    check({sdo, sdv, ovf} == 4'b0, "R1", "outputs in reset", {sdo, sdv, ovf}, 0);
    rst = 1'b0;
    @(negedge clk);
    check({sdo, sdv, ovf} == 4'b0, "R1", "outputs after reset", {sdo, sdv, ovf}, 0);

    // table walk: back-to-back events at minimum spacing (R9)
    for (int v = 0; v < NV; v++) begin
      h = '0; a = '0;
      for (int s = 0; s < 6; s++) begin
        if (TCH[v*6+s] >= 0) begin
          h[TCH[v*6+s]] = 1'b1;
          a[TCH[v*6+s]*3 +: 3] = 3'(TAMP[v*6+s]);
        end
      end
      period(h, a, vreq(v), 0);
    end
    period('0, '0, "R8", 0);
    period('0, '0, "R8", 0);

    // every channel hit: lowest four sent, overflow raised (R4, R5)
    h = '1;
    for (int c = 0; c < NCH; c++) a[c*3 +: 3] = 3'(c % 8);
    period(h, a, "R4", 0);
    // stretched strobe spacing keeps lines idle, flag held (R10)
    period('0, '0, "R10", 10);
    period('0, '0, "R10", 10);

    // reset with two events in flight (R1), then tag restarts at 0 (R2)
    period(h, a, "R1", 0);
    h = '0; a = '0; h[9] = 1'b1; a[27 +: 3] = 3'd6;
    period(h, a, "R1", 0);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({sdo, sdv, ovf} == 4'b0, "R1", "outputs after mid-stream reset", {sdo, sdv, ovf}, 0);
    clear_hist("R1");
    h = '0; a = '0; h[77] = 1'b1; h[20] = 1'b1; a[77*3 +: 3] = 3'd5; a[20*3 +: 3] = 3'd2;
    period(h, a, "R2", 0);
    h = '0; a = '0; h[1] = 1'b1; a[3 +: 3] = 3'd7;
    period(h, a, "R2", 0);
    period('0, '0, "R8", 0);
    period('0, '0, "R8", 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule